// File: doc/BRIEF.md
# Configuration-Space Data Object Mailbox

This block is a request/response mailbox that sits behind four 32-bit configuration registers. Host software builds a request object by writing it into a write-data register one dword at a time. It then sets a GO bit in the control register. The mailbox spends one cycle checking the object header, its length and, for discovery, the index. It then either raises a ready flag with a response waiting or raises an error flag.

The response is drained through a read-data register. A read shows the current dword and changes nothing. Any write to that register moves on to the next dword. Once the last dword is consumed, the ready flag drops and the mailbox is idle again. A discovery request lists the four supported protocols by index, and each answer names the index of the next protocol. The other supported protocols get an answer made of the header only. An abort bit in the control register returns the mailbox to idle from any state.

Top module: `dobj_mailbox`

## Requirements
- R1: After reset, status reads 0 and read-data reads 0.
- R2: The registers sit at fixed offsets: control 0x168, status 0x16C, write-data 0x170, read-data 0x174. Control and write-data always read as 0. Status is {ready[31], 28'b0, error[2], 1'b0, busy[0]}.
- R3: A control write with bit 31 set and bit 0 clear, made while idle, sets busy for exactly one cycle. On the next cycle either ready or error is set.
- R4: For a discovery request (dword0 bits 15:0 = 0x0001, bits 23:16 = 0, length 3), the response has three dwords. Dword 0 echoes request dword 0. Dword 1 is 3 in bits 15:0. Dword 2 holds {next index[31:24], type[23:16], vendor[15:0]} of the entry selected by request dword 2 bits 7:0.
- R5: The table order is: index 0 = (0x0001, 0), index 1 = (0x0001, 1), index 2 = (0x1E98, 0), index 3 = (0x1E98, 2). The next index is index+1, and 0 after index 3.
- R6: A request for any other supported protocol whose length is correct gets a two-dword response: the echoed dword 0, then 2 in bits 15:0.
- R7: A read of read-data returns the current response dword and does not advance. Any write to read-data, whatever its value, advances by one dword.
- R8: Ready clears on the write that consumes the last response dword. Read-data reads 0 whenever ready is clear.
- R9: An unsupported vendor/type pair sets error, never sets ready, and read-data stays 0.
- R10: Error is also set when the length in dword1 bits 15:0 differs from the number of dwords written, or when a discovery index is above 3.
- R11: A control write with bit 0 set clears busy, ready and error, and discards any partly written request.
- R12: While ready or error is set, writes to write-data and GO writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe, one cycle per write |
| addr | input | 12 | Configuration register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |

## Verification
A wrong flag shows on the status register one cycle after GO, because busy must give way to exactly one of ready or error. A wrong response pointer or length shows directly on read-data: a dword comes out of place, repeats after a read, or ready stays set past the last dword. Ignored writes are checked by reading the unchanged status and response right after them.

// File: rtl/dobj_mailbox.sv
module dobj_mailbox #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h168,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h16C,
  parameter logic [ADDR_W-1:0] WDAT_OFS = 12'h170,
  parameter logic [ADDR_W-1:0] RDAT_OFS = 12'h174,
  parameter int REQ_DEPTH = 3,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int NPROT = 4;
  localparam int IW = (REQ_DEPTH > 1) ? $clog2(REQ_DEPTH) : 1;

  function automatic logic [23:0] proto(input int i);
    case (i)
      0:       return {8'h00, 16'h0001};
      1:       return {8'h01, 16'h0001};
      2:       return {8'h00, 16'h1E98};
      default: return {8'h02, 16'h1E98};
    endcase
  endfunction

  logic             busy, ready, err;
  logic [31:0]      req [REQ_DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [31:0]      rsp_hdr, rsp_pay;
  logic [1:0]       rsp_len, rptr;

  wire ctrl_wr = wr_en && addr == CTRL_OFS;
  wire abort   = ctrl_wr && wdata[0];
  wire go      = ctrl_wr && wdata[31] && !wdata[0];
  wire wdat_wr = wr_en && addr == WDAT_OFS;
  wire rdat_wr = wr_en && addr == RDAT_OFS;
  wire idle    = !busy && !ready && !err;

  wire       is_disc = req[0][15:0] == 16'h0001 && req[0][23:16] == 8'h00;
  wire [7:0] idx     = req[2][7:0];
  logic      sup;
  always_comb begin
    sup = 1'b0;
    for (int i = 0; i < NPROT; i++)
      if (proto(i) == req[0][23:0]) sup = 1'b1;
  end
  wire len_ok = cnt >= CNT_W'(2) && req[1][15:0] == 16'(cnt) && (!is_disc || cnt == CNT_W'(3));
  wire idx_ok = !is_disc || idx < 8'(NPROT);
  wire req_ok = sup && len_ok && idx_ok;
  wire [7:0]  nxt = (idx == 8'(NPROT - 1)) ? 8'h00 : idx + 8'h01;
  wire [31:0] entry = {nxt, proto(int'(idx))};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ready <= 1'b0; err <= 1'b0;
      cnt <= '0; rptr <= '0; rsp_len <= '0;
      rsp_hdr <= '0; rsp_pay <= '0;
      for (int i = 0; i < REQ_DEPTH; i++) req[i] <= '0;
    end else if (abort) begin
      busy <= 1'b0; ready <= 1'b0; err <= 1'b0;
      cnt <= '0; rptr <= '0;
    end else if (busy) begin
      busy <= 1'b0;
      cnt  <= '0;
      if (req_ok) begin
        ready   <= 1'b1;
        rptr    <= '0;
        rsp_hdr <= req[0];
        rsp_len <= is_disc ? 2'd3 : 2'd2;
        rsp_pay <= entry;
      end else begin
        err <= 1'b1;
      end
    end else if (idle) begin
      if (go) busy <= 1'b1;
      else if (wdat_wr) begin
        if (cnt < CNT_W'(REQ_DEPTH)) req[cnt[IW-1:0]] <= wdata;
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end else if (ready && rdat_wr) begin
      if (rptr == rsp_len - 2'd1) ready <= 1'b0;
      else rptr <= rptr + 2'd1;
    end
  end

  logic [31:0] rsp_word;
  always_comb begin
    case (rptr)
      2'd0:    rsp_word = rsp_hdr;
      2'd1:    rsp_word = {30'b0, rsp_len};
      default: rsp_word = rsp_pay;
    endcase
  end

  always_comb begin
    if (addr == STAT_OFS)      rdata = {ready, 28'b0, err, 1'b0, busy};
    else if (addr == RDAT_OFS) rdata = ready ? rsp_word : 32'h0;
    else                       rdata = 32'h0;
  end

  assert_ready_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && err));
  assert_busy_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && idle) |=> busy);
  assert_busy_resolves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort) |=> (ready || err));
  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !(busy || ready || err));
  assert_ready_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(rdat_wr || abort));
  assert_rptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wr_en) |=> $stable(rptr));
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !abort) |=> err);
endmodule

// File: tb/dobj_mailbox_test.sv
`timescale 1ns/1ps
module dobj_mailbox_test;
  localparam logic [11:0] CTRL = 12'h168, STAT = 12'h16C, WDAT = 12'h170, RDAT = 12'h174;
  localparam int N = 10;
  localparam logic [15:0] V_VID [N] = '{16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001,
                                        16'h1E98, 16'h1E98, 16'h1E98, 16'h0001, 16'h0001};
  localparam logic [7:0]  V_TYP [N] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd0, 8'd2, 8'd1, 8'd0, 8'd0};
  localparam logic [15:0] V_LEN [N] = '{16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd4, 16'd3};
  localparam logic [7:0]  V_IDX [N] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd4};
  localparam logic        V_ERR [N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [1:0]  V_RLN [N] = '{2'd3, 2'd3, 2'd3, 2'd3, 2'd2, 2'd2, 2'd2, 2'd0, 2'd0, 2'd0};
  localparam logic [31:0] V_PAY [N] = '{32'h0100_0001, 32'h0201_0001, 32'h0300_1E98, 32'h0002_1E98,
                                        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  dobj_mailbox uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2.5 clk = ~clk;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: addr %h got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic send(input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2);
    wr(WDAT, d0); wr(WDAT, d1); wr(WDAT, d2); wr(CTRL, 32'h8000_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", STAT, 32'h0);
    chk("R1 read-data after reset", RDAT, 32'h0);
    chk("R2 control reads zero", CTRL, 32'h0);

    for (int v = 0; v < N; v++) begin
      send({8'h00, V_TYP[v], V_VID[v]}, {16'h0, V_LEN[v]}, {24'h0, V_IDX[v]});
      chk("R3 busy after GO", STAT, 32'h1);
      @(negedge clk);
      if (V_ERR[v]) begin
        chk("R9/R10 error status", STAT, 32'h4);
        chk("R9 no response data", RDAT, 32'h0);
        wr(CTRL, 32'h1);
        chk("R11 abort clears error", STAT, 32'h0);
      end else begin
        chk("R3 ready status", STAT, 32'h8000_0000);
        chk("R4 header echo", RDAT, {8'h00, V_TYP[v], V_VID[v]});
        wr(RDAT, 32'h0);
        chk("R6 response length", RDAT, {30'h0, V_RLN[v]});
        wr(RDAT, 32'hDEAD_BEEF);
        if (V_RLN[v] == 2'd3) begin
          chk("R5 discovery entry", RDAT, V_PAY[v]);
          wr(RDAT, 32'h1);
        end
        chk("R8 ready clear after last", STAT, 32'h0);
        chk("R8 read-data zero when idle", RDAT, 32'h0);
      end
    end

    send(32'h0000_0001, 32'h3, 32'h1);
    @(negedge clk);
    chk("R7 read returns dword0", RDAT, 32'h0000_0001);
    @(negedge clk);
    chk("R7 repeated read does not advance", RDAT, 32'h0000_0001);
    wr(WDAT, 32'h1234_5678);
    wr(CTRL, 32'h8000_0000);
    chk("R12 GO while ready ignored", STAT, 32'h8000_0000);
    chk("R12 write-data while ready ignored", RDAT, 32'h0000_0001);
    wr(RDAT, 32'h0);
    chk("R7 write advances", RDAT, 32'h3);
    wr(CTRL, 32'h1);
    chk("R11 abort clears ready", STAT, 32'h0);
    chk("R11 read-data zero after abort", RDAT, 32'h0);

    send(32'h0005_0001, 32'h3, 32'h0);
    @(negedge clk);
    chk("R9 unsupported type", STAT, 32'h4);
    wr(WDAT, 32'h0000_0001);
    wr(CTRL, 32'h8000_0000);
    @(negedge clk);
    chk("R12 GO while error ignored", STAT, 32'h4);
    wr(CTRL, 32'h1);
    wr(WDAT, 32'hFFFF_FFFF);
    wr(CTRL, 32'h1);
    chk("R11 abort to idle", STAT, 32'h0);
    send(32'h0002_1E98, 32'h3, 32'h0);
    @(negedge clk);
    chk("R11 partial request discarded", STAT, 32'h8000_0000);
    chk("R6 table-access header", RDAT, 32'h0002_1E98);
    wr(CTRL, 32'h1);

    wr(WDAT, 32'h0000_0001);
    wr(WDAT, 32'h2);
    wr(CTRL, 32'h8000_0000);
    @(negedge clk);
    chk("R10 short discovery rejected", STAT, 32'h4);
    wr(CTRL, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule